// File: doc/BRIEF.md
# Multiplexed four-digit display counter

This block is a four-digit decimal event counter that drives a multiplexed seven-segment display. Each falling edge on the count input advances the count by one. The count input is first brought into the system clock domain, so the whole block runs on one clock. A two-bit radix setting picks one of three profiles:

- Decade: four plain decimal digits.
- Clock: minutes, seconds and tenths. The third digit from the right counts to 5, so the display tops out at 9:59.9.
- Half: three and a half digits. The leading digit counts only 0 and 1.

A holding register captures the count while its enable is high and keeps the value once the enable drops. A display select chooses whether the live count or the held value is shown. A scanning state machine (states SCAN_D0, SCAN_D1, SCAN_D2, SCAN_D3) strobes one digit at a time. It steps SCAN_D0 to SCAN_D1 to SCAN_D2 to SCAN_D3 and back to SCAN_D0, one step at each divider tick. The divider ticks once every SCAN_DIV system clocks.

A carry state machine has three states: CY_LOW, CY_MID and CY_OVF. In Decade and Clock modes it moves from CY_LOW to CY_MID when the count steps onto 6000. It returns from CY_MID to CY_LOW when the count wraps to 0000. This gives a cascade pulse for a following counter. In Half mode, a wrap from 1999 to 0000 moves it from CY_LOW or CY_MID into CY_OVF. CY_OVF is only left through reset. The carry output is high in CY_MID and in CY_OVF.

Top module: `mux_display_counter`

## Requirements
- R1: The count advances by exactly one for each falling edge of `count_in`. The update happens on the third rising system-clock edge after the new low level is first sampled. A rising edge of `count_in` leaves the count unchanged.
- R2: While `rst` is high (asynchronous, active high), the live count and the held value are 0000, `carry_out` is 0, and `digit_en` is 4'b0001.
- R3: With `radix_mode` = 0, every digit counts 0 to 9, and the count wraps from 9999 to 0000.
- R4: With `radix_mode` = 1, the third digit from the right (count bits [11:8]) counts 0 to 5, and the count wraps from 9599 to 0000.
- R5: With `radix_mode` = 2, the leading digit (bits [15:12]) counts 0 to 1, and the count wraps from 1999 to 0000.
- R6: With `radix_mode` = 0 or 1, `carry_out` rises on the clock edge where the count becomes 6000. It falls on the edge where the count wraps to 0000.
- R7: With `radix_mode` = 2, `carry_out` rises on the wrap from 1999 to 0000 and then stays high until `rst`.
- R8: While `latch_en` is high, the held value follows the live count in the same cycle. While `latch_en` is low, the held value keeps the last count that was present with `latch_en` high.
- R9: With `disp_sel` = 1 the display shows the live count. With `disp_sel` = 0 it shows the held value.
- R10: `digit_en` is one-hot, with bit 0 for the least significant digit. The active bit moves one place upward (wrapping from bit 3 to bit 0) every SCAN_DIV clocks.
- R11: `seg_out` is active high, with bit 0 = segment a through bit 6 = segment g. Digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex), and the pattern shown is for the digit that `digit_en` selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for scanning and synchronisation |
| rst | input | 1 | Asynchronous active-high reset |
| count_in | input | 1 | Event input, counted on its falling edge |
| latch_en | input | 1 | High: holding register transparent; low: frozen |
| disp_sel | input | 1 | High: show live count; low: show held value |
| radix_mode | input | 2 | 0 Decade, 1 Clock, 2 Half (3 behaves as Decade) |
| seg_out | output | 7 | Segment lines a..g, active high |
| digit_en | output | 4 | One-hot digit strobes, bit 0 least significant |
| carry_out | output | 1 | Cascade carry or sticky overflow |

## Verification
The assertions check the scan strobes on every cycle: they must stay one-hot and may only move one place upward. They also check that each digit stays within its radix, that the carry rises only when the live count is exactly 6000, that the overflow is sticky in Half mode, and that the segments stay still while the held value is shown and frozen. Only the bench scenarios can show the exact wrap points in each mode, the carry falling on wrap, the three-edge count latency, the glyph table, and which held value is captured when `latch_en` drops. These are shown by comparing against a behavioural model on every clock across full count cycles in all three modes.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

    localparam int DIGITS = 4;
    localparam int BCD_W  = 4;
    localparam int CNT_W  = DIGITS * BCD_W;
    localparam int SEG_W  = 7;

    typedef enum logic [1:0] {
        RADIX_DECADE = 2'd0,
        RADIX_CLOCK  = 2'd1,
        RADIX_HALF   = 2'd2
    } radix_e;

    typedef enum logic [1:0] {
        CY_LOW,
        CY_MID,
        CY_OVF
    } carry_e;

    typedef enum logic [1:0] {
        SCAN_D0,
        SCAN_D1,
        SCAN_D2,
        SCAN_D3
    } scan_e;

    // Highest value a digit may hold for the selected radix profile.
    function automatic logic [BCD_W-1:0] digit_limit(input int idx, input logic [1:0] mode);
        if (mode == RADIX_CLOCK && idx == DIGITS - 2) return 4'd5;
        if (mode == RADIX_HALF && idx == DIGITS - 1) return 4'd1;
        return 4'd9;
    endfunction

    // Common-cathode glyphs, bit 0 = segment a .. bit 6 = segment g.
    function automatic logic [SEG_W-1:0] glyph(input logic [BCD_W-1:0] v);
        logic [SEG_W-1:0] s;
        unique case (v)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic fall_o
);

    // sh[0..STAGES-1] synchronise, sh[STAGES] holds the previous level.
    logic [STAGES:0] sh;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], async_in};
        end
    end

    assign fall_o = sh[STAGES] & ~sh[STAGES-1];

endmodule

// File: rtl/bcd_chain.sv
module bcd_chain
    import dcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [1:0]       mode,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_d,
    output logic             wrap_o
);

    logic [DIGITS:0] en;
    assign en[0] = step;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [BCD_W-1:0] cur;
        logic             at_max;
        assign cur      = count_q[g*BCD_W +: BCD_W];
        assign at_max   = (cur >= digit_limit(g, mode));
        assign en[g+1]  = en[g] & at_max;
        assign count_d[g*BCD_W +: BCD_W] = !en[g] ? cur : (at_max ? '0 : cur + 1'b1);
    end

    assign wrap_o = en[DIGITS];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

endmodule

// File: rtl/carry_fsm.sv
module carry_fsm
    import dcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             wrap,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] count_d,
    output logic             carry_o
);

    localparam logic [CNT_W-1:0] MID_COUNT = {4'd6, {(CNT_W-BCD_W){1'b0}}};

    carry_e state_q, state_d;
    logic   half_mode;

    assign half_mode = (mode == RADIX_HALF);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= CY_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CY_LOW: begin
                if (wrap && half_mode) begin
                    state_d = CY_OVF;
                end else if (step && !half_mode && count_d == MID_COUNT) begin
                    state_d = CY_MID;
                end
            end
            CY_MID: begin
                if (wrap) begin
                    state_d = half_mode ? CY_OVF : CY_LOW;
                end
            end
            CY_OVF: begin
                state_d = CY_OVF;
            end
            default: state_d = CY_LOW;
        endcase
    end

    always_comb begin
        unique case (state_q)
            CY_MID:  carry_o = 1'b1;
            CY_OVF:  carry_o = 1'b1;
            default: carry_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/digit_scanner.sv
module digit_scanner
    import dcnt_pkg::*;
#(
    parameter int SCAN_DIV = 25000
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DIGITS-1:0] digit_en,
    output logic [1:0]        sel_o
);

    localparam int DIV_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCAN_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic             tick;
    scan_e            state_q, state_d;

    assign tick = (div_q == DIV_LAST);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= SCAN_D0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                SCAN_D0: state_d = SCAN_D1;
                SCAN_D1: state_d = SCAN_D2;
                SCAN_D2: state_d = SCAN_D3;
                SCAN_D3: state_d = SCAN_D0;
                default: state_d = SCAN_D0;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            SCAN_D0: begin digit_en = 4'b0001; sel_o = 2'd0; end
            SCAN_D1: begin digit_en = 4'b0010; sel_o = 2'd1; end
            SCAN_D2: begin digit_en = 4'b0100; sel_o = 2'd2; end
            SCAN_D3: begin digit_en = 4'b1000; sel_o = 2'd3; end
            default: begin digit_en = 4'b0001; sel_o = 2'd0; end
        endcase
    end

endmodule

// File: rtl/mux_display_counter.sv
module mux_display_counter
    import dcnt_pkg::*;
#(
    parameter int SCAN_DIV    = 25000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       count_in,
    input  logic       latch_en,
    input  logic       disp_sel,
    input  logic [1:0] radix_mode,
    output logic [6:0] seg_out,
    output logic [3:0] digit_en,
    output logic       carry_out
);

    logic             step;
    logic             wrap;
    logic [CNT_W-1:0] live_count;
    logic [CNT_W-1:0] next_count;
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] hold_view;
    logic [CNT_W-1:0] shown;
    logic [1:0]       scan_sel;
    logic [BCD_W-1:0] shown_digit;

    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (count_in),
        .fall_o   (step)
    );

    bcd_chain u_chain (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .mode    (radix_mode),
        .count_q (live_count),
        .count_d (next_count),
        .wrap_o  (wrap)
    );

    carry_fsm u_carry (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .wrap    (wrap),
        .mode    (radix_mode),
        .count_d (next_count),
        .carry_o (carry_out)
    );

    digit_scanner #(.SCAN_DIV(SCAN_DIV)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .digit_en (digit_en),
        .sel_o    (scan_sel)
    );

    // Transparent holding register: flow-through while enabled, stored otherwise.
    assign hold_view = latch_en ? live_count : hold_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_view;
        end
    end

    assign shown = disp_sel ? live_count : hold_view;

    always_comb begin
        shown_digit = '0;
        for (int i = 0; i < DIGITS; i++) begin
            if (scan_sel == 2'(i)) begin
                shown_digit = shown[i*BCD_W +: BCD_W];
            end
        end
    end

    assign seg_out = glyph(shown_digit);

endmodule

// File: rtl/dcnt_checker.sv
module dcnt_checker (
    input logic        clk,
    input logic        rst,
    input logic        latch_en,
    input logic        disp_sel,
    input logic [1:0]  radix_mode,
    input logic [6:0]  seg_out,
    input logic [3:0]  digit_en,
    input logic        carry_out,
    input logic [15:0] live_count
);

    logic [3:0] prev_en;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            prev_en <= 4'b0001;
        end else begin
            prev_en <= digit_en;
        end
    end

    assert_onehot_scan_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(digit_en) == 1);

    assert_scan_order_R10: assert property (@(posedge clk) disable iff (rst)
        (digit_en != prev_en) |-> (digit_en == {prev_en[2:0], prev_en[3]}));

    assert_decimal_digits_R3: assert property (@(posedge clk) disable iff (rst)
        (live_count[3:0] <= 4'd9) && (live_count[7:4] <= 4'd9) &&
        (live_count[11:8] <= 4'd9) && (live_count[15:12] <= 4'd9));

    assert_clock_digit_R4: assert property (@(posedge clk) disable iff (rst)
        (radix_mode == 2'd1 && $past(radix_mode) == 2'd1 && $past(live_count[11:8]) <= 4'd5)
        |-> (live_count[11:8] <= 4'd5));

    assert_half_digit_R5: assert property (@(posedge clk) disable iff (rst)
        (radix_mode == 2'd2 && $past(radix_mode) == 2'd2 && $past(live_count[15:12]) <= 4'd1)
        |-> (live_count[15:12] <= 4'd1));

    assert_mid_rise_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(carry_out) && radix_mode != 2'd2) |-> (live_count == 16'h6000));

    assert_sticky_ovf_R7: assert property (@(posedge clk) disable iff (rst)
        (carry_out && radix_mode == 2'd2) |=> carry_out);

    assert_frozen_view_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(!latch_en && !disp_sel) && !latch_en && !disp_sel && digit_en == prev_en)
        |-> $stable(seg_out));

endmodule

bind mux_display_counter dcnt_checker u_dcnt_checker (
    .clk        (clk),
    .rst        (rst),
    .latch_en   (latch_en),
    .disp_sel   (disp_sel),
    .radix_mode (radix_mode),
    .seg_out    (seg_out),
    .digit_en   (digit_en),
    .carry_out  (carry_out),
    .live_count (live_count)
);

// File: tb/mux_display_counter_bench.sv
module mux_display_counter_bench;

    localparam int SCAN_DIV = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       count_in = 1'b0;
    logic       latch_en = 1'b1;
    logic       disp_sel = 1'b1;
    logic [1:0] radix_mode = 2'd0;
    logic [6:0] seg_out;
    logic [3:0] digit_en;
    logic       carry_out;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R2";
    bit    done = 0;

    // Reference model state
    int m_dg[4];
    int m_held[4];
    int m_carry;
    int m_ovf;
    int m_div;
    int m_sel;
    bit m_hist[$];

    always #5 clk = ~clk;

    mux_display_counter #(.SCAN_DIV(SCAN_DIV)) u_mux_display_counter (
        .clk        (clk),
        .rst        (rst),
        .count_in   (count_in),
        .latch_en   (latch_en),
        .disp_sel   (disp_sel),
        .radix_mode (radix_mode),
        .seg_out    (seg_out),
        .digit_en   (digit_en),
        .carry_out  (carry_out)
    );

    function automatic logic [6:0] ref_glyph(input int v);
        case (v)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
            4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
            8: return 7'h7F;  9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic int lim_of(input int i, input int mode);
        if (mode == 1 && i == 2) return 5;
        if (mode == 2 && i == 3) return 1;
        return 9;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_dg[i] = 0;
            m_held[i] = 0;
        end
        m_carry = 0;
        m_ovf = 0;
        m_div = 0;
        m_sel = 0;
        m_hist = '{0, 0, 0};
    endtask

    initial model_reset();

    // Model update on each rising edge, then compare after outputs settle.
    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            bit stepping;
            bit wrapped;
            stepping = (m_hist[2] == 1'b1) && (m_hist[1] == 1'b0);
            if (latch_en) begin
                for (int i = 0; i < 4; i++) m_held[i] = m_dg[i];
            end
            if (stepping) begin
                bit c;
                c = 1'b1;
                for (int i = 0; i < 4; i++) begin
                    if (c) begin
                        if (m_dg[i] >= lim_of(i, int'(radix_mode))) begin
                            m_dg[i] = 0;
                        end else begin
                            m_dg[i] = m_dg[i] + 1;
                            c = 1'b0;
                        end
                    end
                end
                wrapped = c;
                if (radix_mode == 2'd2) begin
                    if (wrapped) m_ovf = 1;
                end else if (m_ovf == 0) begin
                    if (m_dg[3] == 6 && m_dg[2] == 0 && m_dg[1] == 0 && m_dg[0] == 0) m_carry = 1;
                    if (wrapped) m_carry = 0;
                end
            end
            if (m_div == SCAN_DIV - 1) begin
                m_div = 0;
                m_sel = (m_sel + 1) % 4;
            end else begin
                m_div = m_div + 1;
            end
            m_hist.push_front(count_in);
            void'(m_hist.pop_back());
        end
        #3;
        if (!done) begin
            int shown_v;
            int exp_carry;
            shown_v = (disp_sel || latch_en) ? m_dg[m_sel] : m_held[m_sel];
            exp_carry = (m_ovf != 0) ? 1 : m_carry;
            check(digit_en == 4'(1 << m_sel), "R10 scan strobe", int'(digit_en), 1 << m_sel);
            check(seg_out == ref_glyph(shown_v), {cur_req, " R11 segments"},
                  int'(seg_out), int'(ref_glyph(shown_v)));
            check(carry_out == 1'(exp_carry), {cur_req, " carry"}, int'(carry_out), exp_carry);
        end
    end

    task automatic pulse();
        @(negedge clk) count_in = 1'b1;
        @(negedge clk);
        @(negedge clk) count_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) pulse();
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] mode);
        @(negedge clk) rst = 1'b1;
        radix_mode = mode;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stimulus
        // R2: reset state
        cur_req = "R2";
        repeat (4) @(negedge clk);
        check(carry_out == 1'b0, "R2 carry in reset", int'(carry_out), 0);
        check(digit_en == 4'b0001, "R2 strobe in reset", int'(digit_en), 1);
        check(seg_out == 7'h3F, "R2 R11 zero glyph in reset", int'(seg_out), 'h3F);
        rst = 1'b0;

        // R10 R11: idle scanning of 0000
        cur_req = "R10";
        repeat (20) @(negedge clk);

        // R1: falling edges count, long high levels do not
        cur_req = "R1";
        pulses(7);
        @(negedge clk) count_in = 1'b1;
        repeat (12) @(negedge clk);
        count_in = 1'b0;
        repeat (6) @(negedge clk);

        // R8 R9: freeze the held value and switch the view
        cur_req = "R8";
        latch_en = 1'b0;
        disp_sel = 1'b0;
        pulses(5);
        repeat (12) @(negedge clk);
        cur_req = "R9";
        disp_sel = 1'b1;
        repeat (12) @(negedge clk);
        disp_sel = 1'b0;
        repeat (4) @(negedge clk);
        cur_req = "R8";
        latch_en = 1'b1;
        repeat (12) @(negedge clk);
        disp_sel = 1'b1;

        // R3 R6: decade mode full cycle
        cur_req = "R3 R6";
        do_reset(2'd0);
        pulses(5999);
        settle();
        check(carry_out == 1'b0, "R6 carry at 5999", int'(carry_out), 0);
        pulses(1);
        settle();
        check(carry_out == 1'b1, "R6 carry at 6000", int'(carry_out), 1);
        pulses(3999);
        settle();
        check(carry_out == 1'b1, "R3 carry at 9999", int'(carry_out), 1);
        pulses(1);
        settle();
        check(carry_out == 1'b0, "R3 R6 carry after wrap", int'(carry_out), 0);

        // R4 R6: clock mode full cycle
        cur_req = "R4 R6";
        do_reset(2'd1);
        pulses(3599);
        settle();
        check(carry_out == 1'b0, "R4 carry at 5599", int'(carry_out), 0);
        pulses(1);
        settle();
        check(carry_out == 1'b1, "R4 R6 carry at 6000", int'(carry_out), 1);
        pulses(2400);
        settle();
        check(carry_out == 1'b0, "R4 carry after 9599 wrap", int'(carry_out), 0);

        // R5 R7: half mode wrap and sticky overflow
        cur_req = "R5 R7";
        do_reset(2'd2);
        pulses(1999);
        settle();
        check(carry_out == 1'b0, "R5 overflow at 1999", int'(carry_out), 0);
        pulses(1);
        settle();
        check(carry_out == 1'b1, "R7 overflow after wrap", int'(carry_out), 1);
        pulses(2000);
        settle();
        check(carry_out == 1'b1, "R7 overflow still set", int'(carry_out), 1);
        cur_req = "R2 R7";
        do_reset(2'd2);
        check(carry_out == 1'b0, "R7 R2 overflow cleared by reset", int'(carry_out), 0);
        repeat (8) @(negedge clk);

        done = 1;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule